// File: doc/BRIEF.md
# Receive Packet DMA Clipper

This block sits between a USB receive path and system memory. It takes the data bytes of one incoming data packet and writes them, one byte per memory beat, into the buffer named by a buffer descriptor. The start address, the endpoint's maximum packet size, the packet's PID, the mode (host or device) and the isochronous flag are all captured when the packet starts. The block never writes more than the maximum packet size into the buffer. It produces the handshake decision, writes back the descriptor's token PID field and byte count, raises a token-done pulse, and sets a sticky DMA error flag.

The incoming byte stream has no back-pressure, because the line cannot be paused. A packet opens with a one-cycle `in_start` strobe, continues with bytes marked by `in_valid`, and closes with a one-cycle `in_end` strobe that carries no data. The memory side is a valid/ready port fed from a single-byte holding register. A beat transfers on a cycle where both `mem_valid` and `mem_ready` are high. While `mem_ready` is low, the beat stays presented and does not change. If a byte has to be stored while the holding register is still blocked, the memory is too slow and the packet has a latency overrun.

Top module: `rx_dma_clipper`

## Requirements
- R1: Byte k of a packet (k counted from 0) is written at address `buf_base + k`. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.
- R2: When a packet carries more bytes than `max_pkt`, only the first `max_pkt` bytes reach memory. The surplus bytes are dropped.
- R3: A non-isochronous packet that is oversized but has no overrun is answered with ACK: `hs_valid`=1 and `hs_nak`=0 in the cycle after `in_end`.
- R4: An oversized packet or a latency overrun sets bit 5 of `err_stat`, in the second cycle after `in_end`. The bit stays set until a write of 1 to bit 5 of `err_clr`. `err_irq` is high exactly when a bit is set in both `err_stat` and `err_en`.
- R5: An oversized packet writes back `wb_count` = `max_pkt` and `wb_pid` = the captured packet PID, which is not 4'b1111. It also raises `tok_done`.
- R6: In host mode, a latency overrun writes back `wb_pid` = 4'b1111, raises `tok_done` and gives no handshake. Only the bytes stored before the overrun reach memory.
- R7: In device mode, a latency overrun gives `hs_valid`=1 with `hs_nak`=1. It gives no write-back and no `tok_done`.
- R8: An isochronous packet never gives a handshake. Clipping and error flagging still apply to it.
- R9: A packet that is not oversized writes back `wb_count` equal to the number of bytes received, and 0 for a zero-length packet. `wb_valid` and `tok_done` each pulse for exactly one cycle, in the cycle after `in_end`.
- R10: A latency overrun happens when a byte that must be stored arrives while the holding register is full and `mem_ready` is low. That byte and all later bytes of the packet are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_start | input | 1 | Packet start strobe; captures the descriptor and mode inputs |
| in_end | input | 1 | Packet end strobe; carries no data |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| pkt_pid | input | 4 | PID of the data packet |
| buf_base | input | AW | Buffer start address from the descriptor |
| max_pkt | input | LW | Endpoint maximum packet size |
| host_mode | input | 1 | 1 = host, 0 = device |
| iso_xfer | input | 1 | Isochronous transfer |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | AW | Memory write address |
| mem_data | output | 8 | Memory write byte |
| hs_valid | output | 1 | Handshake decision pulse |
| hs_nak | output | 1 | 1 = NAK, 0 = ACK (meaningful while hs_valid) |
| wb_valid | output | 1 | Descriptor write-back pulse |
| wb_pid | output | 4 | Token PID field written back |
| wb_count | output | LW | Byte count written back |
| tok_done | output | 1 | Token-done interrupt pulse |
| err_stat | output | 8 | Error status; bit 5 = DMA error, write-1-to-clear |
| err_en | input | 8 | Error interrupt enables |
| err_clr | input | 8 | Write-1-to-clear strobe for err_stat |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench sends a packet exactly `max_pkt` long and one longer than that. A design with an off-by-one at the clip edge would either flag the exact-size packet or write one byte too many. The bench stalls memory for a single byte, which must not count as an overrun, and then for a second byte, which must. It tests both modes: a host that sent NAK, or a device that wrote back the 4'b1111 PID, would show the wrong handshake or write-back pulse. The bench also checks zero-length and isochronous packets, and checks that the error bit survives until it is cleared and that `err_irq` follows its enable.

// File: rtl/rxclip_pkg.sv
package rxclip_pkg;
  localparam logic [3:0] PID_LATENCY = 4'hF;
  localparam int         ERR_BITS    = 8;

  typedef enum logic [1:0] {
    OUT_CLEAN = 2'd0,
    OUT_CLIP  = 2'd1,
    OUT_LATE  = 2'd2
  } outcome_e;
endpackage

// File: rtl/rxclip_hold.sv
module rxclip_hold #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          blocked
);
  logic          full_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      addr_q <= load_addr;
      data_q <= load_data;
    end else if (full_q && mem_ready) begin
      full_q <= 1'b0;
    end
  end

  assign mem_valid = full_q;
  assign mem_addr  = addr_q;
  assign mem_data  = data_q;
  assign blocked   = full_q & ~mem_ready;

  // R1: a stalled beat is held unchanged
  a_r1_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R10: the controller never overwrites a blocked beat
  a_r10_no_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(mem_valid && !mem_ready));
endmodule

// File: rtl/rxclip_ctrl.sv
module rxclip_ctrl
  import rxclip_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_start,
  input  logic          in_end,
  input  logic          in_valid,
  input  logic [3:0]    pkt_pid,
  input  logic [AW-1:0] buf_base,
  input  logic [LW-1:0] max_pkt,
  input  logic          host_mode,
  input  logic          iso_xfer,
  input  logic          blocked,
  output logic          load,
  output logic [AW-1:0] load_addr,
  output logic          hs_valid,
  output logic          hs_nak,
  output logic          wb_valid,
  output logic [3:0]    wb_pid,
  output logic [LW-1:0] wb_count,
  output logic          tok_done,
  output logic          err_set
);
  logic          active_q, clip_q, late_q, host_q, iso_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] maxp_q, cnt_q;
  logic [3:0]    pid_q;

  logic     byte_in, room, store, overrun, finish;
  outcome_e outcome;

  always_comb begin
    byte_in   = active_q & in_valid & ~in_start & ~in_end;
    room      = cnt_q < maxp_q;
    store     = byte_in & room & ~late_q;
    overrun   = store & blocked;
    load      = store & ~blocked;
    load_addr = base_q + AW'(cnt_q);
    finish    = active_q & in_end;
    if (late_q)      outcome = OUT_LATE;
    else if (clip_q) outcome = OUT_CLIP;
    else             outcome = OUT_CLEAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      clip_q   <= 1'b0;
      late_q   <= 1'b0;
      host_q   <= 1'b0;
      iso_q    <= 1'b0;
      base_q   <= '0;
      maxp_q   <= '0;
      cnt_q    <= '0;
      pid_q    <= '0;
    end else if (in_start) begin
      active_q <= 1'b1;
      clip_q   <= 1'b0;
      late_q   <= 1'b0;
      host_q   <= host_mode;
      iso_q    <= iso_xfer;
      base_q   <= buf_base;
      maxp_q   <= max_pkt;
      cnt_q    <= '0;
      pid_q    <= pkt_pid;
    end else begin
      if (store)           cnt_q    <= cnt_q + 1'b1;
      if (byte_in && !room) clip_q  <= 1'b1;
      if (overrun)         late_q   <= 1'b1;
      if (finish)          active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_nak   <= 1'b0;
      wb_valid <= 1'b0;
      wb_pid   <= '0;
      wb_count <= '0;
      tok_done <= 1'b0;
      err_set  <= 1'b0;
    end else begin
      hs_valid <= 1'b0;
      hs_nak   <= 1'b0;
      wb_valid <= 1'b0;
      tok_done <= 1'b0;
      err_set  <= 1'b0;
      if (finish) begin
        wb_count <= cnt_q;
        wb_pid   <= pid_q;
        unique case (outcome)
          OUT_LATE: begin
            err_set <= 1'b1;
            if (host_q) begin
              wb_valid <= 1'b1;
              tok_done <= 1'b1;
              wb_pid   <= PID_LATENCY;
            end else begin
              hs_valid <= ~iso_q;
              hs_nak   <= ~iso_q;
            end
          end
          OUT_CLIP: begin
            err_set  <= 1'b1;
            wb_valid <= 1'b1;
            tok_done <= 1'b1;
            hs_valid <= ~iso_q;
          end
          default: begin
            wb_valid <= 1'b1;
            tok_done <= 1'b1;
            hs_valid <= ~iso_q;
          end
        endcase
      end
    end
  end

  // R5: a written-back count never exceeds the maximum packet size
  a_r5_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_count <= maxp_q);
  // R6: the latency PID only appears in host mode
  a_r6_late_pid_host: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_pid == PID_LATENCY |-> host_q);
  // R7: a NAK carries no completion
  a_r7_nak_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid && hs_nak |-> !wb_valid && !tok_done);
  // R8: isochronous packets get no handshake
  a_r8_no_hs_iso: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> !iso_q);
  // R9: the completion is a single-cycle pulse
  a_r9_single_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
endmodule

// File: rtl/rxclip_err.sv
module rxclip_err
  import rxclip_pkg::*;
#(
  parameter int DMA_BIT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set,
  input  logic [ERR_BITS-1:0] clr,
  input  logic [ERR_BITS-1:0] en,
  output logic [ERR_BITS-1:0] stat,
  output logic                irq
);
  localparam logic [ERR_BITS-1:0] DMA_MASK = ERR_BITS'(1) << DMA_BIT;

  logic [ERR_BITS-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~clr) | (set ? DMA_MASK : '0)) & DMA_MASK;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & en);

  // R4: the flag is set after a request
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> stat[DMA_BIT]);
  // R4: the flag is sticky until cleared
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat[DMA_BIT] && !clr[DMA_BIT] |=> stat[DMA_BIT]);
endmodule

// File: rtl/rx_dma_clipper.sv
module rx_dma_clipper
  import rxclip_pkg::*;
#(
  parameter int AW      = 16,
  parameter int LW      = 11,
  parameter int DMA_BIT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_start,
  input  logic                in_end,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  input  logic [3:0]          pkt_pid,
  input  logic [AW-1:0]       buf_base,
  input  logic [LW-1:0]       max_pkt,
  input  logic                host_mode,
  input  logic                iso_xfer,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [AW-1:0]       mem_addr,
  output logic [7:0]          mem_data,
  output logic                hs_valid,
  output logic                hs_nak,
  output logic                wb_valid,
  output logic [3:0]          wb_pid,
  output logic [LW-1:0]       wb_count,
  output logic                tok_done,
  output logic [ERR_BITS-1:0] err_stat,
  input  logic [ERR_BITS-1:0] err_en,
  input  logic [ERR_BITS-1:0] err_clr,
  output logic                err_irq
);
  logic          load, blocked, err_set;
  logic [AW-1:0] load_addr;

  rxclip_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_end(in_end),
    .in_valid(in_valid), .pkt_pid(pkt_pid), .buf_base(buf_base),
    .max_pkt(max_pkt), .host_mode(host_mode), .iso_xfer(iso_xfer),
    .blocked(blocked), .load(load), .load_addr(load_addr),
    .hs_valid(hs_valid), .hs_nak(hs_nak), .wb_valid(wb_valid),
    .wb_pid(wb_pid), .wb_count(wb_count), .tok_done(tok_done),
    .err_set(err_set)
  );

  rxclip_hold #(.AW(AW), .DW(8)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
    .load_data(in_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .blocked(blocked)
  );

  rxclip_err #(.DMA_BIT(DMA_BIT)) u_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .en(err_en),
    .stat(err_stat), .irq(err_irq)
  );
endmodule

// File: tb/rx_dma_clipper_tb.sv
module rx_dma_clipper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 11;
  localparam logic [AW-1:0] BASE = 16'h1200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_start = 0, in_end = 0, in_valid = 0;
  logic [7:0] in_data = 0;
  logic [3:0] pkt_pid = 0;
  logic [AW-1:0] buf_base = 0;
  logic [LW-1:0] max_pkt = 0;
  logic host_mode = 0, iso_xfer = 0, mem_ready = 1;
  logic [7:0] err_en = 0, err_clr = 0;
  logic mem_valid, hs_valid, hs_nak, wb_valid, tok_done, err_irq;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data, err_stat;
  logic [3:0] wb_pid;
  logic [LW-1:0] wb_count;

  int errors = 0, checks = 0, wr_n = 0;
  logic [AW-1:0] wa [0:31];
  logic [7:0]    wd [0:31];
  logic c_hs, c_nak, c_wb, c_tok, a_pulse, a_irq;
  logic [3:0] c_pid;
  logic [LW-1:0] c_cnt;
  logic [7:0] a_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dma_clipper #(.AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_end(in_end),
    .in_valid(in_valid), .in_data(in_data), .pkt_pid(pkt_pid),
    .buf_base(buf_base), .max_pkt(max_pkt), .host_mode(host_mode),
    .iso_xfer(iso_xfer), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .hs_valid(hs_valid),
    .hs_nak(hs_nak), .wb_valid(wb_valid), .wb_pid(wb_pid),
    .wb_count(wb_count), .tok_done(tok_done), .err_stat(err_stat),
    .err_en(err_en), .err_clr(err_clr), .err_irq(err_irq)
  );

  always @(posedge clk)
    if (rst_n && mem_valid && mem_ready) begin
      if (wr_n < 32) begin
        wa[wr_n] = mem_addr;
        wd[wr_n] = mem_data;
      end
      wr_n = wr_n + 1;
    end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep(input logic [7:0] en);
    @(posedge clk); #1;
    err_en = en; err_clr = 8'hFF;
    @(posedge clk); #1;
    err_clr = 8'h00; wr_n = 0;
  endtask

  task automatic check_writes(input string req, input int n);
    chk(req, wr_n, n);
    for (int i = 0; i < n && i < 32; i++) begin
      chk(req, int'(wa[i]), int'(BASE) + i);
      chk(req, int'(wd[i]), 8'h40 + i);
    end
  endtask

  task automatic send(input int n, input int maxp, input logic host,
                      input logic iso, input logic [3:0] pid, input logic stall);
    @(posedge clk); #1;
    mem_ready = ~stall; buf_base = BASE; max_pkt = LW'(maxp);
    host_mode = host; iso_xfer = iso; pkt_pid = pid; in_start = 1;
    @(posedge clk); #1;
    in_start = 0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = 8'(8'h40 + i);
      @(posedge clk); #1;
    end
    in_valid = 0; in_end = 1;
    @(posedge clk); #1;
    in_end = 0;
    c_hs = hs_valid; c_nak = hs_nak; c_wb = wb_valid; c_tok = tok_done;
    c_pid = wb_pid; c_cnt = wb_count;
    @(posedge clk); #1;
    a_pulse = wb_valid | tok_done | hs_valid;
    a_err = err_stat; a_irq = err_irq;
    mem_ready = 1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R9 reset wb_valid", wb_valid, 0);
    chk("R9 reset tok_done", tok_done, 0);
    chk("R3 reset hs_valid", hs_valid, 0);
    chk("R1 reset mem_valid", mem_valid, 0);
    chk("R4 reset err_stat", err_stat, 0);
    chk("R4 reset err_irq", err_irq, 0);
  endtask

  task automatic t_normal();
    prep(8'h20);
    send(5, 8, 0, 0, 4'b0011, 0);
    chk("R9 wb_valid", c_wb, 1);
    chk("R9 tok_done", c_tok, 1);
    chk("R9 count", c_cnt, 5);
    chk("R9 pid", c_pid, 4'b0011);
    chk("R3 ack", {c_hs, c_nak}, 2'b10);
    chk("R9 single pulse", a_pulse, 0);
    chk("R4 no error", a_err, 0);
    check_writes("R1 writes", 5);
  endtask

  task automatic t_zero_len();
    prep(8'h00);
    send(0, 8, 0, 0, 4'b1011, 0);
    chk("R9 zlp wb", c_wb, 1);
    chk("R9 zlp count", c_cnt, 0);
    chk("R9 zlp writes", wr_n, 0);
  endtask

  task automatic t_exact();
    prep(8'h20);
    send(4, 4, 0, 0, 4'b0011, 0);
    chk("R2 exact count", c_cnt, 4);
    chk("R2 exact no error", a_err, 0);
    check_writes("R2 exact writes", 4);
  endtask

  task automatic t_oversize();
    prep(8'h20);
    send(10, 4, 0, 0, 4'b1011, 0);
    chk("R3 ack on oversize", {c_hs, c_nak}, 2'b10);
    chk("R5 count clipped", c_cnt, 4);
    chk("R5 pid kept", c_pid, 4'b1011);
    chk("R5 tok_done", c_tok, 1);
    chk("R4 dma bit", a_err, 8'h20);
    chk("R4 irq enabled", a_irq, 1);
    check_writes("R2 clipped writes", 4);
    chk("R4 sticky", err_stat, 8'h20);
    err_clr = 8'h20;
    @(posedge clk); #1;
    err_clr = 8'h00;
    chk("R4 w1c clear", err_stat, 0);
    chk("R4 irq low", err_irq, 0);
  endtask

  task automatic t_iso();
    prep(8'h00);
    send(6, 3, 0, 1, 4'b0011, 0);
    chk("R8 no handshake", c_hs, 0);
    chk("R8 wb still", c_wb, 1);
    chk("R8 clipped count", c_cnt, 3);
    chk("R8 error flagged", a_err, 8'h20);
    chk("R4 irq masked", a_irq, 0);
    check_writes("R8 clipped writes", 3);
  endtask

  task automatic t_host_late();
    prep(8'h20);
    send(3, 8, 1, 0, 4'b0011, 1);
    chk("R6 wb_valid", c_wb, 1);
    chk("R6 latency pid", c_pid, 4'hF);
    chk("R6 tok_done", c_tok, 1);
    chk("R6 no handshake", c_hs, 0);
    chk("R4 error on latency", a_err, 8'h20);
    check_writes("R10 only first byte", 1);
  endtask

  task automatic t_dev_late();
    prep(8'h20);
    send(3, 8, 0, 0, 4'b1011, 1);
    chk("R7 nak", {c_hs, c_nak}, 2'b11);
    chk("R7 no wb", c_wb, 0);
    chk("R7 no tok_done", c_tok, 0);
    check_writes("R10 device first byte", 1);
  endtask

  task automatic t_stall_one();
    prep(8'h20);
    @(posedge clk); #1;
    mem_ready = 0; buf_base = BASE; max_pkt = 8; host_mode = 0;
    iso_xfer = 0; pkt_pid = 4'b0011; in_start = 1;
    @(posedge clk); #1;
    in_start = 0; in_valid = 1; in_data = 8'h40;
    @(posedge clk); #1;
    in_valid = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R1 held valid", mem_valid, 1);
      chk("R1 held addr", mem_addr, BASE);
      chk("R1 held data", mem_data, 8'h40);
      @(posedge clk); #1;
    end
    in_end = 1;
    @(posedge clk); #1;
    in_end = 0;
    chk("R10 stall without overrun is ack", {hs_valid, hs_nak}, 2'b10);
    chk("R10 count", wb_count, 1);
    mem_ready = 1;
    repeat (3) @(posedge clk);
    #1;
    check_writes("R1 drained", 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_normal();
    t_zero_len();
    t_exact();
    t_oversize();
    t_iso();
    t_host_late();
    t_dev_late();
    t_stall_one();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule